// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit microcontroller core. It takes two operands, the current carry and zero status bits, and a 4-bit operation code. From these it produces a result byte, a destination write strobe, a six-bit flag vector and a matching six-bit update mask. The surrounding core merges each flag whose mask bit is set into its status register and keeps every other flag as it was. When an instruction carries an immediate constant, the decoder places it on the second operand.

The operations are addition with or without carry, subtraction with or without borrow, bitwise AND, OR and XOR, one's complement, two's complement negation, increment, decrement, load-all-ones, and compare with or without borrow. Every operation completes within the cycle that presents it. Compares produce flags but never request a write.

The borrow-chained forms can only clear the zero flag and never set it. This lets a multi-byte subtract or compare report "equal" only if every byte was equal.

Top module: `alu8_core`

## Requirements
- R1: op_i 0 (add) and 1 (add with carry) give res_o = a_i + b_i (+ carry_i for code 1) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is the signed overflow. The mask covers all six flags.
- R2: op_i 2 (subtract) and 3 (subtract with borrow) give res_o = a_i - b_i (- carry_i for code 3) mod 256. C is the borrow out of bit 7, H is the borrow into bit 4, and V is the signed overflow. The mask covers all six flags.
- R3: For codes 3 and 13, Z = zero_i AND (8-bit difference == 0). For every other code that updates Z, Z = (res_o == 0).
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result with V = 0. The mask holds only Z, N, V and S, so C and H keep their values.
- R5: Codes 9 (increment) and 10 (decrement) give a_i + 1 and a_i - 1 mod 256. V is set only when stepping 0x7F to 0x80 (increment) or 0x80 to 0x7F (decrement). The mask holds only Z, N, V and S.
- R6: Code 7 (one's complement) gives 0xFF - a_i with C = 1 and V = 0. The mask holds C, Z, N, V and S but not H.
- R7: Code 8 (negate) gives 0x00 - a_i. C is set when the result is nonzero, H is the borrow into bit 4, and V is set only for the result 0x80. The mask covers all six flags.
- R8: Code 11 (load ones) gives res_o = 0xFF with wr_en_o = 1 and a mask of zero.
- R9: Codes 12 (compare) and 13 (compare with borrow) set the flags and res_o exactly as codes 2 and 3 would, with wr_en_o = 0.
- R10: The flag vector bits are C = bit 0, Z = bit 1, N = bit 2, V = bit 3, S = bit 4 and H = bit 5. N is bit 7 of res_o, and S = N XOR V whenever N is updated. A flag whose mask bit is 0 reads as 0 in flags_o.
- R11: wr_en_o = 1 for codes 0 to 11. Codes 14 and 15 give res_o = 0, wr_en_o = 0 and a zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand (source register or immediate) |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag, used by the borrow-chained forms |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Destination write strobe |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| flag_upd_o | output | 6 | Per-flag update mask, same bit order |

## Verification
The bench sweeps every operand pair for each two-operand code, and every carry and zero combination for the chained forms. It therefore hits the nibble boundaries that drive H, the 0x7F/0x80 edges that drive V, and the zero-difference case of the chained forms. A design that takes H from the wrong bit, or V from unsigned carry, produces wrong flags at those edges. A design that sets Z on a zero chained difference breaks multi-byte equality, and one that writes back on a compare corrupts the destination. Directed checks cover the masks of the logic, increment and complement codes, load-ones, and the unused codes, where a wrongly masked C or H would silently destroy a carry chain.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 6;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_COM = 4'd7;
  localparam logic [3:0] OP_NEG = 4'd8;
  localparam logic [3:0] OP_INC = 4'd9;
  localparam logic [3:0] OP_DEC = 4'd10;
  localparam logic [3:0] OP_SET = 4'd11;
  localparam logic [3:0] OP_CMP = 4'd12;
  localparam logic [3:0] OP_CPC = 4'd13;

  // bit order {h,s,v,n,z,c}
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam logic [NFLAG-1:0] UPD_ALL   = 6'b111111;
  localparam logic [NFLAG-1:0] UPD_ZNVS  = 6'b011110;
  localparam logic [NFLAG-1:0] UPD_CZNVS = 6'b011111;
  localparam logic [NFLAG-1:0] UPD_NONE  = 6'b000000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  input  logic          ci_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  localparam int HB = DW / 2;

  logic [DW-1:0] y_eff;
  logic          cin_eff;
  logic [DW:0]   full;
  logic [HB:0]   low;

  // subtract as x + ~y + ~borrow; carry outputs inverted to borrows
  assign y_eff   = sub_i ? ~y_i : y_i;
  assign cin_eff = sub_i ? ~ci_i : ci_i;
  assign full    = {1'b0, x_i} + {1'b0, y_eff} + {{DW{1'b0}}, cin_eff};
  assign low     = {1'b0, x_i[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, cin_eff};

  assign sum_o = full[DW-1:0];
  assign c_o   = full[DW] ^ sub_i;
  assign h_o   = low[HB] ^ sub_i;
  assign v_o   = (x_i[DW-1] == y_eff[DW-1]) && (full[DW-1] != x_i[DW-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_flag_gen.sv
module alu8_flag_gen
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]    res_i,
  input  logic             c_i,
  input  logic             h_i,
  input  logic             v_i,
  input  logic             chain_i,
  input  logic             zero_prev_i,
  input  logic [NFLAG-1:0] upd_i,
  output logic [NFLAG-1:0] flags_o
);
  flags_t f;
  logic   is_zero;

  assign is_zero = (res_i == '0);

  always_comb begin
    f.c = c_i;
    f.h = h_i;
    f.v = v_i;
    f.n = res_i[DW-1];
    f.s = f.n ^ f.v;
    f.z = chain_i ? (is_zero & zero_prev_i) : is_zero;
  end

  assign flags_o = f & upd_i;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [3:0]       op_i,
  input  logic             carry_i,
  input  logic             zero_i,
  output logic [DW-1:0]    res_o,
  output logic             wr_en_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] flag_upd_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0]    x, y, asum, lres;
  logic             sub, ci, ac, ah, av;
  logic [1:0]       lsel;
  logic             use_logic, use_set, use_none, chain, wr;
  logic [NFLAG-1:0] upd;

  always_comb begin
    x = a_i; y = b_i; sub = 1'b0; ci = 1'b0;
    lsel = 2'd0; use_logic = 1'b0; use_set = 1'b0; use_none = 1'b0;
    chain = 1'b0; wr = 1'b1; upd = UPD_ALL;
    unique case (op_i)
      OP_ADD: ;
      OP_ADC: ci = carry_i;
      OP_SUB: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; ci = carry_i; chain = 1'b1; end
      OP_AND: begin use_logic = 1'b1; lsel = 2'd0; upd = UPD_ZNVS; end
      OP_OR:  begin use_logic = 1'b1; lsel = 2'd1; upd = UPD_ZNVS; end
      OP_XOR: begin use_logic = 1'b1; lsel = 2'd2; upd = UPD_ZNVS; end
      OP_COM: begin use_logic = 1'b1; lsel = 2'd3; upd = UPD_CZNVS; end
      OP_NEG: begin x = '0; y = a_i; sub = 1'b1; end
      OP_INC: begin y = ONE; upd = UPD_ZNVS; end
      OP_DEC: begin y = ONE; sub = 1'b1; upd = UPD_ZNVS; end
      OP_SET: begin use_set = 1'b1; upd = UPD_NONE; end
      OP_CMP: begin sub = 1'b1; wr = 1'b0; end
      OP_CPC: begin sub = 1'b1; ci = carry_i; chain = 1'b1; wr = 1'b0; end
      default: begin use_none = 1'b1; wr = 1'b0; upd = UPD_NONE; end
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x_i(x), .y_i(y), .sub_i(sub), .ci_i(ci),
    .sum_o(asum), .c_o(ac), .h_o(ah), .v_o(av)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(lsel), .res_o(lres)
  );

  always_comb begin
    if (use_none)       res_o = '0;
    else if (use_set)   res_o = '1;
    else if (use_logic) res_o = lres;
    else                res_o = asum;
  end

  // logic group: C forced 1 (only kept by complement), V forced 0
  alu8_flag_gen #(.DW(DW)) u_flags (
    .res_i(res_o),
    .c_i(use_logic ? 1'b1 : ac),
    .h_i(ah),
    .v_i(use_logic ? 1'b0 : av),
    .chain_i(chain),
    .zero_prev_i(zero_i),
    .upd_i(upd),
    .flags_o(flags_o)
  );

  assign wr_en_o    = wr;
  assign flag_upd_o = upd;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic [DW-1:0]    a_i,
  input logic [DW-1:0]    b_i,
  input logic [3:0]       op_i,
  input logic             carry_i,
  input logic             zero_i,
  input logic [DW-1:0]    res_o,
  input logic             wr_en_o,
  input logic [NFLAG-1:0] flags_o,
  input logic [NFLAG-1:0] flag_upd_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, op_i, carry_i, zero_i, res_o, wr_en_o, flags_o, flag_upd_o});

  always_comb begin
    if (known) begin
      a_r10_s_is_n_xor_v: assert (!flag_upd_o[2] || (flags_o[4] == (flags_o[2] ^ flags_o[3])))
        else $error("S flag not N^V");
      a_r10_unmasked_zero: assert ((flags_o & ~flag_upd_o) == '0)
        else $error("unmasked flag nonzero");
      a_r10_n_is_msb: assert (!flag_upd_o[2] || (flags_o[2] == res_o[DW-1]))
        else $error("N not result msb");
      a_r9_cmp_no_write: assert (!((op_i == OP_CMP) || (op_i == OP_CPC)) || !wr_en_o)
        else $error("compare requested write");
      a_r8_set_ones: assert ((op_i != OP_SET) || ((res_o == '1) && (flag_upd_o == '0) && wr_en_o))
        else $error("load-ones wrong");
      a_r6_com_carry: assert ((op_i != OP_COM) || (flags_o[0] && !flag_upd_o[5]))
        else $error("complement carry or H mask wrong");
      a_r3_chain_z: assert (!((op_i == OP_SBC) || (op_i == OP_CPC)) || zero_i || !flags_o[1])
        else $error("chained Z set without prior Z");
      a_r3_plain_z: assert ((op_i == OP_SBC) || (op_i == OP_CPC) || !flag_upd_o[1] ||
                            (flags_o[1] == (res_o == '0)))
        else $error("Z does not match result");
      a_r4_logic_v: assert (!((op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR)) ||
                            (!flags_o[3] && (flag_upd_o[0] == 1'b0) && (flag_upd_o[5] == 1'b0)))
        else $error("logic op V or C/H mask wrong");
      a_r11_unused_idle: assert ((op_i < 4'd14) || (!wr_en_o && (flag_upd_o == '0)))
        else $error("unused code had effect");
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (.*);

// File: tb/alu8_core_test.sv
`timescale 1ns/100ps
module alu8_core_test;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [3:0] op;
  logic       c, z;
  logic [7:0] res;
  logic       wr;
  logic [5:0] flg, upd;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alu8_core uut (
    .a_i(a), .b_i(b), .op_i(op), .carry_i(c), .zero_i(z),
    .res_o(res), .wr_en_o(wr), .flags_o(flg), .flag_upd_o(upd)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: got cycles=%0d exp finish earlier", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // independent reference: integer arithmetic, flags {H,S,V,N,Z,C}
  task automatic ref_model(input int o, input int ai, input int bi, input int ci, input int zi,
                           output logic [7:0] er, output logic ew,
                           output logic [5:0] ef, output logic [5:0] em);
    int full, sr, x, y, k;
    bit cf, hf, vf, zf, nf, chained;
    cf = 0; hf = 0; vf = 0; ew = 1; em = 6'b111111; er = 8'h00; chained = 0;
    case (o)
      0, 1: begin
        k = (o == 1) ? ci : 0;
        full = ai + bi + k; er = full[7:0];
        cf = full > 255; hf = ((ai % 16) + (bi % 16) + k) > 15;
        sr = sgn(ai) + sgn(bi) + k; vf = (sr > 127) || (sr < -128);
      end
      2, 3, 8, 12, 13: begin
        if (o == 8) begin x = 0; y = ai; end else begin x = ai; y = bi; end
        k = (o == 3 || o == 13) ? ci : 0;
        chained = (o == 3 || o == 13);
        full = x - y - k; er = full[7:0];
        cf = full < 0; hf = ((x % 16) - (y % 16) - k) < 0;
        sr = sgn(x) - sgn(y) - k; vf = (sr > 127) || (sr < -128);
        ew = (o < 12);
      end
      4: begin er = 8'(ai & bi); em = 6'b011110; end
      5: begin er = 8'(ai | bi); em = 6'b011110; end
      6: begin er = 8'(ai ^ bi); em = 6'b011110; end
      7: begin er = 8'(255 - ai); cf = 1; em = 6'b011111; end
      9: begin full = ai + 1; er = full[7:0]; vf = (ai == 127); em = 6'b011110; end
      10: begin full = ai - 1; er = full[7:0]; vf = (ai == 128); em = 6'b011110; end
      11: begin er = 8'hFF; em = 6'b000000; end
      default: begin er = 8'h00; ew = 0; em = 6'b000000; end
    endcase
    nf = er[7];
    zf = (er == 8'h00) && (!chained || zi != 0);
    ef = {hf, nf ^ vf, vf, nf, zf, cf} & em;
  endtask

  task automatic apply_check(input string tag, input int o, input int ai, input int bi,
                             input int ci, input int zi);
    logic [7:0] er; logic ew; logic [5:0] ef, em;
    op = o[3:0]; a = ai[7:0]; b = bi[7:0]; c = ci[0]; z = zi[0];
    #1;
    ref_model(o, ai, bi, ci, zi, er, ew, ef, em);
    n_chk++;
    if (res !== er || wr !== ew || flg !== ef || upd !== em) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d z=%0d: got res=%h wr=%b flags=%b upd=%b exp res=%h wr=%b flags=%b upd=%b",
               tag, o, ai, bi, ci, zi, res, wr, flg, upd, er, ew, ef, em);
    end
  endtask

  task automatic sweep(input string tag, input int o, input int nb, input int nc, input int nz);
    for (int ai = 0; ai < 256; ai++)
      for (int bi = 0; bi < nb; bi++)
        for (int ci = 0; ci < nc; ci++)
          for (int zi = 0; zi < nz; zi++)
            apply_check(tag, o, ai, bi, ci, zi);
  endtask

  task automatic t_idle;
    apply_check("R1 idle inputs zero", 0, 0, 0, 0, 0);
  endtask

  task automatic t_r1_add;
    apply_check("R1 0x0F+0x01 half carry", 0, 8'h0F, 8'h01, 0, 0);
    apply_check("R1 0x7F+0x01 overflow", 0, 8'h7F, 8'h01, 0, 0);
    sweep("R1 add", 0, 256, 1, 1);
    sweep("R1 add with carry", 1, 256, 2, 1);
  endtask

  task automatic t_r2_r3_sub;
    sweep("R2 subtract", 2, 256, 1, 1);
    apply_check("R3 chained zero kept clear", 3, 8'h10, 8'h10, 0, 0);
    apply_check("R3 chained zero kept set", 3, 8'h10, 8'h10, 0, 1);
    sweep("R2/R3 subtract with borrow", 3, 256, 2, 2);
  endtask

  task automatic t_r4_logic;
    sweep("R4 and", 4, 256, 1, 1);
    sweep("R4 or", 5, 256, 1, 1);
    sweep("R4 xor", 6, 256, 1, 1);
  endtask

  task automatic t_r5_incdec;
    apply_check("R5 inc 0x7F", 9, 8'h7F, 0, 0, 0);
    apply_check("R5 dec 0x80", 10, 8'h80, 0, 0, 0);
    sweep("R5 increment", 9, 1, 1, 1);
    sweep("R5 decrement", 10, 1, 1, 1);
  endtask

  task automatic t_r6_com;
    sweep("R6 complement", 7, 1, 1, 1);
  endtask

  task automatic t_r7_neg;
    apply_check("R7 neg 0x00", 8, 8'h00, 0, 0, 0);
    apply_check("R7 neg 0x80", 8, 8'h80, 0, 0, 0);
    sweep("R7 negate", 8, 1, 1, 1);
  endtask

  task automatic t_r8_set;
    sweep("R8 load ones", 11, 1, 2, 1);
  endtask

  task automatic t_r9_cmp;
    sweep("R9 compare", 12, 256, 1, 1);
    sweep("R9/R3 compare with borrow", 13, 256, 2, 2);
  endtask

  task automatic t_r10_flags;
    apply_check("R10 S=N^V overflow", 2, 8'h80, 8'h01, 0, 0);
    apply_check("R10 S=N^V negative", 2, 8'h00, 8'h01, 0, 0);
    apply_check("R10 masked C H read zero", 4, 8'hFF, 8'h0F, 1, 1);
  endtask

  task automatic t_r11_unused;
    apply_check("R11 code 14", 14, 8'hAA, 8'h55, 1, 1);
    apply_check("R11 code 15", 15, 8'hFF, 8'hFF, 1, 0);
  endtask

  initial begin
    a = 0; b = 0; op = 0; c = 0; z = 0;
    #2;
    t_idle();
    t_r1_add();
    t_r2_r3_sub();
    t_r4_logic();
    t_r5_incdec();
    t_r6_com();
    t_r7_neg();
    t_r8_set();
    t_r9_cmp();
    t_r10_flags();
    t_r11_unused();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule